// File: doc/BRIEF.md
# Tiled-Address Chunk Copier

This block moves one contiguous span of bytes between a linear buffer and a tiled buffer. It works in fixed 16-byte chunks. A caller gives a source offset, a destination offset, a byte length and two flags that say which side is tiled, then pulses `start`. The block then reads each chunk into a 16-byte holding register and writes it out. Each read and each write is a request/acknowledge exchange on its own memory port.

On the tiled side, each chunk address is passed through a fixed shuffle of address bits 4 to 8. This is the reorder a tile uses inside itself. Every other address bit goes through unchanged. On a linear side the address is the plain base plus the chunk offset. Requests that are not 16-byte aligned, or that mark both sides as tiled, are refused with an error pulse and cause no memory traffic.

Top module: `tile_swz_copier`

## Requirements
- R1: After reset, `rd_req`, `wr_req`, `done`, `err` and `busy` are all low.
- R2: An accepted transfer of length L issues exactly L/16 read/write chunk pairs. Chunk k uses the byte offset 16*k added to each base, with k counting up from 0.
- R3: A chunk's write is issued only after its read is acknowledged. `wr_data` equals the `rd_data` that was present on that read acknowledge. `rd_req` and `wr_req` are never high together.
- R4: Tiling remap: the result keeps every address bit except 4 to 8, and sets out[4]=in[6], out[5]=in[4], out[6]=in[7], out[7]=in[8], out[8]=in[5].
- R5: Address bits below 4 and above 8 are identical before and after the remap.
- R6: With `src_tiled`=1 and `dst_tiled`=0, the read address is the remap of (src_off + 16k). The write address is dst_off + 16k, not remapped.
- R7: With `src_tiled`=0 and `dst_tiled`=1, the read address is src_off + 16k, not remapped. The write address is the remap of (dst_off + 16k).
- R8: With both flags 0, both addresses are the plain sums, with no remap.
- R9: If any of `src_off`, `dst_off` or `xfer_len` has a nonzero value in bits [3:0] at start, `err` is high for exactly the one cycle after start. No read or write request follows, and `done` stays low.
- R10: If both `src_tiled` and `dst_tiled` are 1 at start, the request is refused in the same way as in R9.
- R11: `done` is high for exactly one cycle, in the cycle after the last chunk's write is acknowledged. `busy` is low from that cycle on.
- R12: An aligned start with `xfer_len`=0 gives a one-cycle `done` in the next cycle and no requests.
- R13: A `start` pulse while `busy` is high is ignored. The transfer in progress keeps its original addresses and chunk count.
- R14: While a request is high and not yet acknowledged, it stays high, and its address (and its write data) hold steady.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Launch pulse, taken only when idle |
| src_tiled | input | 1 | Source side uses the tiled layout |
| dst_tiled | input | 1 | Destination side uses the tiled layout |
| src_off | input | ADDR_W | Source byte offset |
| dst_off | input | ADDR_W | Destination byte offset |
| xfer_len | input | LEN_W | Span length in bytes |
| busy | output | 1 | Transfer in progress |
| rd_req | output | 1 | Chunk read request |
| rd_addr | output | ADDR_W | Chunk read address |
| rd_ack | input | 1 | Read accepted, rd_data valid |
| rd_data | input | DATA_W | Read chunk data |
| wr_req | output | 1 | Chunk write request |
| wr_addr | output | ADDR_W | Chunk write address |
| wr_data | output | DATA_W | Chunk write data |
| wr_ack | input | 1 | Write accepted |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle refusal pulse |

## Verification
The assertions take for granted that `rd_ack` and `wr_ack` are raised only while the matching request is high. They also assume the memory side never acknowledges both ports in the same cycle. The stimulus holds to this: it raises each acknowledge for exactly one cycle, and only after it has seen the request. It adds a per-scenario wait of a few cycles, so the hold-steady rule is tested under real back-pressure. Offsets are chosen so that `xfer_len` plus either base never wraps the address width. That keeps the expected sums simple.

// File: rtl/swz_pkg.sv
package swz_pkg;

  localparam int CHUNK_BYTES = 16;
  localparam int CHUNK_LSB   = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } xfer_state_e;

  // Reorder of the five in-tile address bits [8:4].
  // out4<-in6, out5<-in4, out6<-in7, out7<-in8, out8<-in5
  function automatic logic [4:0] tile_bits(input logic [4:0] b);
    // b[0]=bit4 .. b[4]=bit8
    return {b[1], b[4], b[3], b[0], b[2]};
  endfunction

  // Alignment test on a chunk boundary.
  function automatic logic off_chunk(input logic [CHUNK_LSB-1:0] low);
    return |low;
  endfunction

endpackage

// File: rtl/swz_addr_gen.sv
module swz_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  chunk_off,
  input  logic              tiled,
  output logic [ADDR_W-1:0] addr
);
  logic [ADDR_W-1:0] lin_sum;
  logic [ADDR_W-1:0] remapped;

  always_comb begin
    lin_sum  = base + ADDR_W'(chunk_off);
    remapped = lin_sum;
    remapped[8:4] = swz_pkg::tile_bits(lin_sum[8:4]);
    addr = tiled ? remapped : lin_sum;
  end
endmodule

// File: rtl/swz_hold_reg.sv
module swz_hold_reg #(
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= '0;
    else if (cap_en) q <= d;
  end
endmodule

// File: rtl/swz_chunk_ctrl.sv
module swz_chunk_ctrl #(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             req_bad,
  input  logic             req_zero,
  input  logic [LEN_W-1:0] len_q,
  input  logic             rd_ack,
  input  logic             wr_ack,
  output logic             launch,
  output logic [LEN_W-1:0] chunk_off,
  output logic             rd_req,
  output logic             wr_req,
  output logic             cap_en,
  output logic             busy,
  output logic             done,
  output logic             err
);
  import swz_pkg::*;

  localparam logic [LEN_W:0] STEP = (LEN_W+1)'(CHUNK_BYTES);

  xfer_state_e      state_q;
  logic [LEN_W-1:0] chunk_q;
  logic             done_q;
  logic             err_q;
  logic             last_chunk;
  logic             rd_fire;
  logic             wr_fire;

  assign launch     = start && (state_q == ST_IDLE);
  assign rd_req     = (state_q == ST_READ);
  assign wr_req     = (state_q == ST_WRITE);
  assign rd_fire    = rd_req && rd_ack;
  assign wr_fire    = wr_req && wr_ack;
  assign cap_en     = rd_fire;
  assign busy       = (state_q != ST_IDLE);
  assign last_chunk = ({1'b0, chunk_q} + STEP) >= {1'b0, len_q};
  assign chunk_off  = chunk_q;
  assign done       = done_q;
  assign err        = err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      chunk_q <= '0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (req_bad)       err_q  <= 1'b1;
            else if (req_zero) done_q <= 1'b1;
            else begin
              chunk_q <= '0;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: begin
          if (rd_fire) state_q <= ST_WRITE;
        end
        ST_WRITE: begin
          if (wr_fire) begin
            if (last_chunk) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              chunk_q <= chunk_q + LEN_W'(CHUNK_BYTES);
              state_q <= ST_READ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tile_swz_copier.sv
module tile_swz_copier #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16,
  parameter int DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              src_tiled,
  input  logic              dst_tiled,
  input  logic [ADDR_W-1:0] src_off,
  input  logic [ADDR_W-1:0] dst_off,
  input  logic [LEN_W-1:0]  xfer_len,
  output logic              busy,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_ack,
  input  logic [DATA_W-1:0] rd_data,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              done,
  output logic              err
);
  import swz_pkg::*;

  localparam int SIDES = 2;

  logic              launch;
  logic              req_bad;
  logic              req_zero;
  logic              cap_en;
  logic [LEN_W-1:0]  chunk_off;
  logic [ADDR_W-1:0] src_q;
  logic [ADDR_W-1:0] dst_q;
  logic [LEN_W-1:0]  len_q;
  logic              src_tiled_q;
  logic              dst_tiled_q;

  logic [ADDR_W-1:0] side_base  [SIDES];
  logic              side_tiled [SIDES];
  logic [ADDR_W-1:0] side_addr  [SIDES];

  assign req_bad  = off_chunk(src_off[CHUNK_LSB-1:0]) ||
                    off_chunk(dst_off[CHUNK_LSB-1:0]) ||
                    off_chunk(xfer_len[CHUNK_LSB-1:0]) ||
                    (src_tiled && dst_tiled);
  assign req_zero = (xfer_len == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q       <= '0;
      dst_q       <= '0;
      len_q       <= '0;
      src_tiled_q <= 1'b0;
      dst_tiled_q <= 1'b0;
    end else if (launch) begin
      src_q       <= src_off;
      dst_q       <= dst_off;
      len_q       <= xfer_len;
      src_tiled_q <= src_tiled;
      dst_tiled_q <= dst_tiled;
    end
  end

  swz_chunk_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .req_bad   (req_bad),
    .req_zero  (req_zero),
    .len_q     (len_q),
    .rd_ack    (rd_ack),
    .wr_ack    (wr_ack),
    .launch    (launch),
    .chunk_off (chunk_off),
    .rd_req    (rd_req),
    .wr_req    (wr_req),
    .cap_en    (cap_en),
    .busy      (busy),
    .done      (done),
    .err       (err)
  );

  assign side_base[0]  = src_q;
  assign side_tiled[0] = src_tiled_q;
  assign side_base[1]  = dst_q;
  assign side_tiled[1] = dst_tiled_q;

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    swz_addr_gen #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_agen (
      .base      (side_base[s]),
      .chunk_off (chunk_off),
      .tiled     (side_tiled[s]),
      .addr      (side_addr[s])
    );
  end

  assign rd_addr = side_addr[0];
  assign wr_addr = side_addr[1];

  swz_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk    (clk),
    .rst_n  (rst_n),
    .cap_en (cap_en),
    .d      (rd_data),
    .q      (wr_data)
  );
endmodule

// File: rtl/swz_copier_chk.sv
module swz_copier_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 128
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              rd_req,
  input logic              rd_ack,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              wr_req,
  input logic              wr_ack,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              done,
  input logic              err
);
  // R3
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req && wr_req));

  // R3
  write_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_req) |-> $past(rd_req && rd_ack));

  // R14
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

  // R14
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  // R9
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R9
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!rd_req && !wr_req && !done && !busy));

  // R2
  chunk_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_addr[3:0] == 4'd0));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !rd_req && !wr_req));

  // R11
  done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(busy)) |-> $past(wr_req && wr_ack));
endmodule

bind tile_swz_copier swz_copier_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .busy    (busy),
  .rd_req  (rd_req),
  .rd_ack  (rd_ack),
  .rd_addr (rd_addr),
  .wr_req  (wr_req),
  .wr_ack  (wr_ack),
  .wr_addr (wr_addr),
  .wr_data (wr_data),
  .done    (done),
  .err     (err)
);

// File: tb/tb_tile_swz_copier.sv
`timescale 1ns/1ps
module tb_tile_swz_copier;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int DATA_W = 128;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic              src_tiled = 1'b0;
  logic              dst_tiled = 1'b0;
  logic [ADDR_W-1:0] src_off = '0;
  logic [ADDR_W-1:0] dst_off = '0;
  logic [LEN_W-1:0]  xfer_len = '0;
  logic              busy;
  logic              rd_req;
  logic [ADDR_W-1:0] rd_addr;
  logic              rd_ack = 1'b0;
  logic [DATA_W-1:0] rd_data = '0;
  logic              wr_req;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic              wr_ack = 1'b0;
  logic              done;
  logic              err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tile_swz_copier #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W)) dut (.*);

  task automatic check(input logic ok, input string tag,
                       input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Remap restated as a table of source bit indices for out bits 4..8.
  function automatic logic [ADDR_W-1:0] ref_remap(input logic [ADDR_W-1:0] a);
    int src_idx [5] = '{6, 4, 7, 8, 5};
    logic [ADDR_W-1:0] r = a;
    for (int i = 0; i < 5; i++) r[4+i] = a[src_idx[i]];
    return r;
  endfunction

  function automatic logic [DATA_W-1:0] pattern(input logic [ADDR_W-1:0] a);
    return {a, ~a, a ^ 32'h5A5A_5A5A, a + 32'd1};
  endfunction

  // Runs one accepted transfer and checks every request against expectation.
  task automatic run_xfer(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                          input int len, input logic st, input logic dt,
                          input int dly, input logic poke, input string tag);
    int nchunks = len / 16;
    @(negedge clk);
    src_off = s; dst_off = d; xfer_len = LEN_W'(len);
    src_tiled = st; dst_tiled = dt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < nchunks; k++) begin
      logic [ADDR_W-1:0] exp_rd = s + ADDR_W'(16 * k);
      logic [ADDR_W-1:0] exp_wr = d + ADDR_W'(16 * k);
      if (st) exp_rd = ref_remap(exp_rd);
      if (dt) exp_wr = ref_remap(exp_wr);
      // R2 R4 R5 R6 R7 R8 read side
      check(rd_req && !wr_req, {tag, " R3 read phase"}, {rd_req, wr_req}, 2'b10);
      check(rd_addr == exp_rd, {tag, " R2 R4 R5 read addr"}, rd_addr, exp_rd);
      if (poke && k == 0) begin
        start = 1'b1; src_off = 32'hDEAD_0000; dst_off = 32'hBEEF_0000;
        xfer_len = 16'h0010; src_tiled = ~st; dst_tiled = 1'b0;
      end
      for (int w = 0; w < dly; w++) begin
        @(negedge clk);
        start = 1'b0;
        // R14
        check(rd_req && rd_addr == exp_rd, {tag, " R14 read held"}, rd_addr, exp_rd);
      end
      rd_ack = 1'b1; rd_data = pattern(exp_rd);
      @(negedge clk);
      rd_ack = 1'b0; rd_data = '0; start = 1'b0;
      check(wr_req && !rd_req, {tag, " R3 write phase"}, {rd_req, wr_req}, 2'b01);
      check(wr_addr == exp_wr, {tag, " R6 R7 R8 write addr"}, wr_addr, exp_wr);
      check(wr_data == pattern(exp_rd), {tag, " R3 write data"}, wr_data, pattern(exp_rd));
      for (int w = 0; w < dly; w++) begin
        @(negedge clk);
        check(wr_req && wr_addr == exp_wr && wr_data == pattern(exp_rd),
              {tag, " R14 write held"}, wr_addr, exp_wr);
      end
      wr_ack = 1'b1;
      @(negedge clk);
      wr_ack = 1'b0;
      if (k == nchunks - 1) begin
        check(done && !busy, {tag, " R11 done after last write"}, {done, busy}, 2'b10);
      end else begin
        check(!done, {tag, " R11 no early done"}, done, 1'b0);
      end
    end
    @(negedge clk);
    check(!done && !busy && !rd_req && !wr_req, {tag, " R2 R11 quiet after"},
          {done, busy, rd_req, wr_req}, 4'b0000);
  endtask

  // Request that must be refused.
  task automatic run_refuse(input logic [ADDR_W-1:0] s, input logic [ADDR_W-1:0] d,
                            input int len, input logic st, input logic dt, input string tag);
    @(negedge clk);
    src_off = s; dst_off = d; xfer_len = LEN_W'(len);
    src_tiled = st; dst_tiled = dt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(err && !rd_req && !wr_req && !done, {tag, " err pulse"},
          {err, rd_req, wr_req, done}, 4'b1000);
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      check(!err && !rd_req && !wr_req && !done && !busy, {tag, " stays quiet"},
            {err, rd_req, wr_req, done, busy}, 5'b0);
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    check(!rd_req && !wr_req && !done && !err && !busy, "R1 reset state",
          {rd_req, wr_req, done, err, busy}, 5'b0);
  endtask

  task automatic t_zero_len();
    @(negedge clk);
    src_off = 32'h100; dst_off = 32'h200; xfer_len = '0;
    src_tiled = 1'b0; dst_tiled = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(done && !rd_req && !wr_req && !err, "R12 zero length done",
          {done, rd_req, wr_req, err}, 4'b1000);
    @(negedge clk);
    check(!done && !rd_req && !busy, "R12 zero length single pulse",
          {done, rd_req, busy}, 3'b000);
  endtask

  task automatic t_remap_fn();
    // R4 R5 single-bit walk on a source-tiled read of one chunk
    for (int b = 4; b <= 8; b++) begin
      logic [ADDR_W-1:0] a = 32'hF000_0000 | (32'd1 << b);
      run_xfer(a, 32'h0000_4000, 16, 1'b1, 1'b0, 0, 1'b0, "R4 walk");
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    run_xfer(32'h0001_0000, 32'h0002_0040, 64, 1'b0, 1'b0, 0, 1'b0, "R8 linear");
    run_xfer(32'hABCD_E1F0, 32'h0000_0300, 96, 1'b1, 1'b0, 1, 1'b0, "R6 src tiled");
    run_xfer(32'h0000_0800, 32'h7654_3FD0, 80, 1'b0, 1'b1, 2, 1'b0, "R7 dst tiled");
    run_xfer(32'h0000_1000, 32'h0000_2000, 48, 1'b1, 1'b0, 2, 1'b1, "R13 start busy");
    t_remap_fn();
    run_refuse(32'h0000_1004, 32'h0000_2000, 32, 1'b0, 1'b0, "R9 src misaligned");
    run_refuse(32'h0000_1000, 32'h0000_2008, 32, 1'b0, 1'b1, "R9 dst misaligned");
    run_refuse(32'h0000_1000, 32'h0000_2000, 33, 1'b1, 1'b0, "R9 len misaligned");
    run_refuse(32'h0000_1000, 32'h0000_2000, 32, 1'b1, 1'b1, "R10 both tiled");
    t_zero_len();
    run_xfer(32'h0000_0000, 32'h0000_0100, 16, 1'b0, 1'b0, 0, 1'b0, "R2 single chunk");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule